// File: doc/BRIEF.md
# Oscillator Stabilization Status Counter

This block measures how long an external crystal oscillator has been running. It counts oscillator clock edges and presents the elapsed time as an 8-bit thermometer word. The word fills from the top bit down at eight thresholds that grow by powers of two: 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 cycles. Software reads the word, either as a whole byte or as one bit at a time, to decide whether the oscillator is stable enough to switch the CPU onto it. A separate 3-bit limit selector stops the count at one of the eight thresholds. A "stabilized" flag reports that the selected threshold has been reached.

The count runs in the oscillator clock domain. A controller FSM has three states:
- **CLEAR**: the counter is held at zero.
- **COUNT**: the counter advances by one per oscillator edge.
- **HOLD**: the counter is frozen at the selected threshold.

The transitions are:
- **restart** (CLEAR→COUNT): taken once the synchronized clear has dropped.
- **reach** (COUNT→HOLD): taken when the count equals or passes the selected limit.
- **resume** (HOLD→COUNT): taken if a higher limit is selected later.
- **flush** (any→CLEAR): taken whenever the synchronized clear is high.

Two clear sources, stop-mode entry and oscillator disable, are ORed together and synchronized into the oscillator domain. The chip reset acts asynchronously on both domains. The status word and the flag travel to the bus clock domain through a two-flop synchronizer. Each bit there changes at most once between clears, so sampling the bits separately is safe.

The limit selector is configuration. It is changed only while a clear is held.

Top module: `osc_stab_status`

## Requirements
- R1: Status bit 7 sets after 2^8 counted oscillator cycles. Bits 6, 5, 4, 3, 2, 1 and 0 set after 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 cycles respectively.
- R2: Bits set strictly from bit 7 downward and stay set until a clear. The status only ever holds 00h, 80h, C0h, E0h, F0h, F8h, FCh, FEh or FFh.
- R3: While reset is low, and after it, the status is 00h and stabilized is 0. The status stays 00h until at least 2^8 cycles have been counted.
- R4: Reset low, clr_stop high or clr_osc_off high returns the status to 00h and stabilized to 0. Counting restarts from zero once every clear source is released.
- R5: lim_sel values 0 to 7 select the thresholds 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 in that order. The count saturates there, so status bits for higher thresholds never set, however long the oscillator runs.
- R6: stabilized becomes 1 when the count reaches the selected threshold, which is together with status bit (7 − lim_sel). It returns to 0 on any clear.
- R7: With rd_bit_mode = 0, rd_data equals the status byte. With rd_bit_mode = 1, rd_data[0] is status bit rd_bit_sel and rd_data[7:1] are 0.
- R8: Only oscillator edges advance the count. While the oscillator clock does not toggle, the status does not progress. It progresses again once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal oscillator clock being measured |
| bus_clk | input | 1 | Bus clock for the status read side |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| clr_stop | input | 1 | Clear request from stop-mode entry (level) |
| clr_osc_off | input | 1 | Clear request from oscillator disable (level) |
| lim_sel | input | 3 | Stabilization limit selector |
| rd_bit_mode | input | 1 | 0: byte read, 1: single-bit read |
| rd_bit_sel | input | 3 | Bit index for a single-bit read |
| status | output | 8 | Thermometer status, bus domain |
| stabilized | output | 1 | Selected threshold reached, bus domain |
| rd_data | output | 8 | Read data for the selected access width |

## Verification
Once the clear is released, counting begins on the third oscillator edge. The bit for threshold T latches on oscillator edge T+4 and reaches `status` after two more bus clock edges. A clear empties the status within three oscillator edges plus two bus edges. `rd_data` follows `status` combinationally. Each threshold is therefore checked twice: once at T−4 oscillator edges after release, where the bit must still be clear, and once at T+30, where it must be set. Both samples are taken on a falling bus clock edge. Clears and resets are checked after a 20 bus-cycle settle, which covers both synchronizers.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;

    localparam int CNT_W       = 19;
    localparam int STAT_W      = 8;
    localparam int SEL_W       = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } stab_state_e;

    // exponent of the threshold chosen by a selector value
    function automatic int unsigned limit_exp(input logic [SEL_W-1:0] sel);
        int unsigned e;
        case (sel)
            3'd0:    e = 8;
            3'd1:    e = 9;
            3'd2:    e = 10;
            3'd3:    e = 11;
            3'd4:    e = 13;
            3'd5:    e = 15;
            3'd6:    e = 17;
            default: e = 18;
        endcase
        return e;
    endfunction

    function automatic logic [CNT_W-1:0] limit_cycles(input logic [SEL_W-1:0] sel);
        return {{(CNT_W-1){1'b0}}, 1'b1} << limit_exp(sel);
    endfunction

endpackage

// File: rtl/osc_stab_sync.sv
module osc_stab_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/osc_stab_counter.sv
module osc_stab_counter
    import osc_stab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SEL_W-1:0]  lim_sel,
    output logic [STAT_W-1:0] stat_q,
    output logic              hold
);

    stab_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   thr_sel;
    logic               at_limit;
    logic [STAT_W-1:0]  hit;

    assign thr_sel  = limit_cycles(lim_sel);
    assign at_limit = (cnt_q >= thr_sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // transitions: flush, restart, reach, resume
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR: state_d = ST_COUNT;
                ST_COUNT: if (at_limit)  state_d = ST_HOLD;
                ST_HOLD:  if (!at_limit) state_d = ST_COUNT;
                default:  state_d = ST_CLEAR;
            endcase
        end
    end

    // saturating cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (state_q == ST_COUNT && !at_limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // one comparator per status bit, top bit is the lowest threshold
    for (genvar i = 0; i < STAT_W; i++) begin : g_hit
        assign hit[STAT_W-1-i] = (cnt_q >= limit_cycles(SEL_W'(i)));
    end

    // sticky thermometer bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stat_q <= '0;
        else if (clr) stat_q <= '0;
        else          stat_q <= stat_q | hit;
    end

    // outputs
    always_comb begin
        hold = (state_q == ST_HOLD);
    end

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && stat_q == '0));

    a_r2_thermo_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) ||
        (stat_q == (STAT_W'({STAT_W{1'b1}}) << (STAT_W - $countones(stat_q)))));

    a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= thr_sel) |=> (!$stable(lim_sel) || cnt_q <= thr_sel));

    a_r3_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < limit_cycles(SEL_W'(0))) |-> (stat_q == '0));

endmodule

// File: rtl/osc_stab_rdport.sv
module osc_stab_rdport
    import osc_stab_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    input  logic              bit_mode,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [STAT_W-1:0] rd_data
);

    always_comb begin
        if (bit_mode) rd_data = {{(STAT_W-1){1'b0}}, stat[bit_sel]};
        else          rd_data = stat;
    end

endmodule

// File: rtl/osc_stab_status.sv
module osc_stab_status
    import osc_stab_pkg::*;
(
    input  logic              osc_clk,
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              clr_stop,
    input  logic              clr_osc_off,
    input  logic [SEL_W-1:0]  lim_sel,
    input  logic              rd_bit_mode,
    input  logic [SEL_W-1:0]  rd_bit_sel,
    output logic [STAT_W-1:0] status,
    output logic              stabilized,
    output logic [STAT_W-1:0] rd_data
);

    logic              clr_any;
    logic              clr_osc;
    logic [STAT_W-1:0] stat_osc;
    logic              hold_osc;
    logic [STAT_W:0]   xfer_bus;

    assign clr_any = clr_stop | clr_osc_off;

    osc_stab_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clr_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (clr_any),
        .q     (clr_osc)
    );

    osc_stab_counter u_counter (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .clr     (clr_osc),
        .lim_sel (lim_sel),
        .stat_q  (stat_osc),
        .hold    (hold_osc)
    );

    osc_stab_sync #(.W(STAT_W+1), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk   (bus_clk),
        .rst_n (rst_n),
        .d     ({hold_osc, stat_osc}),
        .q     (xfer_bus)
    );

    assign status     = xfer_bus[STAT_W-1:0];
    assign stabilized = xfer_bus[STAT_W];

    osc_stab_rdport u_rdport (
        .stat     (status),
        .bit_mode (rd_bit_mode),
        .bit_sel  (rd_bit_sel),
        .rd_data  (rd_data)
    );

    a_r6_flag_has_bit: assert property (@(posedge bus_clk) disable iff (!rst_n)
        stabilized |-> status[SEL_W'(STAT_W-1) - lim_sel]);

    a_r7_bit_read_upper: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rd_bit_mode |-> (rd_data[STAT_W-1:1] == '0 && rd_data[0] == status[rd_bit_sel]));

endmodule

// File: tb/sim_osc_stab_status.sv
`timescale 1ns/1ps
module sim_osc_stab_status;

    localparam int BUS_PERIOD = 10;
    localparam int OSC_PERIOD = 2;
    localparam int WDOG_CYC   = 150000;

    logic       osc_clk = 1'b0;
    logic       bus_clk = 1'b0;
    logic       rst_n;
    logic       clr_stop;
    logic       clr_osc_off;
    logic [2:0] lim_sel;
    logic       rd_bit_mode;
    logic [2:0] rd_bit_sel;
    logic [7:0] status;
    logic       stabilized;
    logic [7:0] rd_data;

    bit          osc_run = 1'b1;
    int unsigned oscn = 0;
    int unsigned base = 0;
    int          n_run = 0;
    int          n_fail = 0;

    typedef struct {
        string      req;
        bit         rd;
        logic [7:0] exp;
        logic       exp_stab;
    } item_t;

    item_t q[$];

    osc_stab_status u0 (
        .osc_clk     (osc_clk),
        .bus_clk     (bus_clk),
        .rst_n       (rst_n),
        .clr_stop    (clr_stop),
        .clr_osc_off (clr_osc_off),
        .lim_sel     (lim_sel),
        .rd_bit_mode (rd_bit_mode),
        .rd_bit_sel  (rd_bit_sel),
        .status      (status),
        .stabilized  (stabilized),
        .rd_data     (rd_data)
    );

    initial forever #(BUS_PERIOD/2) bus_clk = ~bus_clk;

    initial forever begin
        #(OSC_PERIOD/2);
        if (osc_run) osc_clk = ~osc_clk;
    end

    always @(posedge osc_clk) oscn <= oscn + 1;

    function automatic int unsigned thr(input int i);
        case (i)
            0: return 256;
            1: return 512;
            2: return 1024;
            3: return 2048;
            4: return 8192;
            5: return 32768;
            6: return 131072;
            default: return 262144;
        endcase
    endfunction

    function automatic logic [7:0] therm(input int n);
        logic [7:0] v = '0;
        for (int k = 0; k < n; k++) v[7-k] = 1'b1;
        return v;
    endfunction

    // monitor: pops expected items and compares on a falling bus edge
    initial forever begin
        item_t it;
        wait (q.size() != 0);
        @(negedge bus_clk);
        it = q.pop_front();
        n_run++;
        if (it.rd) begin
            if (rd_data !== it.exp) begin
                n_fail++;
                $display("FAIL %s rd_data actual=%02h expected=%02h", it.req, rd_data, it.exp);
            end
        end else begin
            if (status !== it.exp || stabilized !== it.exp_stab) begin
                n_fail++;
                $display("FAIL %s status/stab actual=%02h/%0b expected=%02h/%0b",
                         it.req, status, stabilized, it.exp, it.exp_stab);
            end
        end
    end

    task automatic expect_stat(input string req, input logic [7:0] e, input logic s);
        item_t it;
        it.req = req; it.rd = 1'b0; it.exp = e; it.exp_stab = s;
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    task automatic expect_rd(input string req, input logic mode, input logic [2:0] sel,
                             input logic [7:0] e);
        item_t it;
        @(negedge bus_clk);
        rd_bit_mode = mode;
        rd_bit_sel  = sel;
        it.req = req; it.rd = 1'b1; it.exp = e; it.exp_stab = 1'b0;
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    task automatic wait_rel(input int unsigned t);
        wait (oscn - base >= t);
    endtask

    task automatic release_clear();
        @(negedge bus_clk);
        clr_stop    = 1'b0;
        clr_osc_off = 1'b0;
        base        = oscn;
    endtask

    // full walk over thresholds 0..last with before/after checks
    task automatic walk(input int last, input string tag);
        for (int i = 0; i <= last; i++) begin
            wait_rel(thr(i) - 4);
            expect_stat(i == 0 ? "R3" : tag, therm(i), 1'b0);
            wait_rel(thr(i) + 30);
            expect_stat(i == last ? "R6" : "R1", therm(i + 1), i == last);
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge bus_clk);
        n_fail++;
        n_run++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        clr_stop    = 1'b1;
        clr_osc_off = 1'b0;
        lim_sel     = 3'd2;
        rd_bit_mode = 1'b0;
        rd_bit_sel  = 3'd0;
        repeat (5) @(posedge bus_clk);
        expect_stat("R3", 8'h00, 1'b0);
        expect_rd("R7", 1'b0, 3'd0, 8'h00);
        @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (5) @(posedge bus_clk);
        release_clear();

        // limit 2: E0h and saturation
        walk(2, "R1");
        wait_rel(4096 + 64);
        expect_stat("R5", 8'hE0, 1'b1);
        expect_rd("R7", 1'b0, 3'd0, 8'hE0);
        expect_rd("R7", 1'b1, 3'd5, 8'h01);
        expect_rd("R7", 1'b1, 3'd4, 8'h00);
        expect_rd("R7", 1'b1, 3'd7, 8'h01);
        expect_rd("R7", 1'b1, 3'd0, 8'h00);
        @(negedge bus_clk);
        rd_bit_mode = 1'b0;

        // oscillator-disable clear, then full range
        clr_osc_off = 1'b1;
        repeat (20) @(posedge bus_clk);
        expect_stat("R4", 8'h00, 1'b0);
        lim_sel = 3'd7;
        repeat (3) @(posedge bus_clk);
        release_clear();
        walk(7, "R2");
        wait_rel(thr(7) + 2000);
        expect_stat("R5", 8'hFF, 1'b1);

        // stop-mode clear, oscillator held still
        clr_stop = 1'b1;
        repeat (20) @(posedge bus_clk);
        expect_stat("R4", 8'h00, 1'b0);
        osc_run = 1'b0;
        repeat (5) @(posedge bus_clk);
        release_clear();
        repeat (400) @(posedge bus_clk);
        expect_stat("R8", 8'h00, 1'b0);
        osc_run = 1'b1;
        wait_rel(thr(0) + 30);
        expect_stat("R8", 8'h80, 1'b0);

        // reset mid-run
        @(negedge bus_clk);
        rst_n = 1'b0;
        repeat (3) @(posedge bus_clk);
        expect_stat("R4", 8'h00, 1'b0);
        @(negedge bus_clk);
        rst_n = 1'b1;
        base  = oscn;
        wait_rel(thr(0) - 4);
        expect_stat("R3", 8'h00, 1'b0);
        wait_rel(thr(0) + 30);
        expect_stat("R4", 8'h80, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule